// File: doc/BRIEF.md
# Lockable CRT and Flat-Panel Display Timing Generator

This block produces the raster timing for a display controller. A horizontal counter runs across each line and a vertical counter steps once per line. Window comparators on those counters give active video, blanking, CRT horizontal and vertical sync, and a separate horizontal and vertical sync pair for a flat panel. The panel pair has its own timing registers, so panel vertical sync can be placed earlier than the CRT sync.

Every timing register holds two values, each programmed as the intended count minus one. The low halfword is the start-type value and the high halfword is the end-type value. A configuration register turns on the generator and gates each output group. All registers except the key register are write-protected until a 16-bit key is written. Pixel data is a placeholder input that is passed to the output only during active video.

Top module: `disp_tgen`

## Requirements
- R1: A write to offset 0x00 whose bits 15:0 equal 0x4758 unlocks the register file, and bits 31:16 are ignored. Any other value written there locks it again. The block comes out of reset locked. A read of 0x00 returns the unlock state in bit 0 and zero in every other bit.
- R2: While the block is locked, a write to any offset other than 0x00 changes no register. This holds for the configuration register, so a locked write cannot change the outputs.
- R3: Reads at 0x08, 0x30, 0x34, 0x38, 0x3C, 0x40, 0x44, 0x48 and 0x4C return the stored 32-bit value, whether the block is locked or unlocked. Reads at unmapped offsets return 0.
- R4: In every timing register, bits 15:0 hold the start-type value minus one and bits 31:16 hold the end-type value minus one. The offsets are:
  - 0x30: horizontal active and total.
  - 0x34: horizontal blank start and blank end.
  - 0x38: horizontal sync start and sync end.
  - 0x3C: panel horizontal sync.
  - 0x40, 0x44, 0x48: the same three vertical pairs.
  - 0x4C: panel vertical sync.
- R5: The configuration register is at 0x08. When its bit 5 (generator enable) is set, the horizontal counter counts from 0 up to the stored total at 0x30 bits 31:16, then returns to 0. The vertical counter advances only on that wrap. It returns to 0 after the stored total at 0x40 bits 31:16.
- R6: When bit 5 is clear, both counters go to 0 on the next clock edge and stay there. In the same cycle, all four sync outputs are low, blank_o is high and active_o is low.
- R7: active_o is high when all of the following hold:
  - bit 5 and bit 3 (blank enable) are set;
  - hcnt is at most the stored horizontal active value;
  - vcnt is at most the stored vertical active value.

  pix_o equals pix_i while active_o is high and is 0 otherwise.
- R8: blank_o is high in any of these cases:
  - bit 3 is clear;
  - hcnt is above the stored blank start and at most the stored blank end at 0x34;
  - vcnt meets the same test against 0x44.
- R9: hsync_o is high when bit 1 is set and hcnt lies between the sync start and sync end at 0x38, both inclusive. vsync_o is high when bit 2 is set and vcnt lies in the same kind of inclusive window at 0x48.
- R10: The panel sync pair uses the same inclusive window rule, on hcnt against 0x3C and on vcnt against 0x4C. It is gated only by bit 0 (panel enable) and bit 5, not by bits 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| pix_i | input | PIX_W | Placeholder pixel data |
| pix_o | output | PIX_W | Pixel data, gated by active video |
| hcnt_o | output | CNT_W | Horizontal counter |
| vcnt_o | output | CNT_W | Vertical counter |
| active_o | output | 1 | Active video |
| blank_o | output | 1 | Blank |
| hsync_o | output | 1 | CRT horizontal sync, active high |
| vsync_o | output | 1 | CRT vertical sync, active high |
| fp_hsync_o | output | 1 | Panel horizontal sync, active high |
| fp_vsync_o | output | 1 | Panel vertical sync, active high |

## Verification
The assertions check the following on every cycle:
- a locked write leaves the whole register file unchanged;
- the key sets the unlock state and any other value clears it;
- the counters fall to zero when the generator is disabled;
- the horizontal counter wraps at the stored total;
- the vertical counter holds except at a horizontal wrap.

The window placement of active, blank and each sync against the programmed values can only be shown by the bench's frame sweeps. The same applies to the earlier panel vertical sync, the gating by each configuration bit, and disabling in mid-frame. The bench checks every output on every cycle against an arithmetic model of the raster.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned N_SLOT = 9;
  localparam int unsigned N_WIN  = 8;

  localparam logic [15:0] UNLOCK_KEY = 16'h4758;
  localparam logic [7:0]  A_KEY      = 8'h00;

  // slot order: cfg, h active/total, h blank, h sync, panel h, v active/total, v blank, v sync, panel v
  localparam int unsigned S_CFG = 0, S_HTOT = 1, S_HBLK = 2, S_HSYN = 3, S_PHSYN = 4;
  localparam int unsigned S_VTOT = 5, S_VBLK = 6, S_VSYN = 7, S_PVSYN = 8;
  localparam logic [7:0] SLOT_ADDR [N_SLOT] =
    '{8'h08, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C};

  localparam int unsigned B_PDAT = 0, B_HSE = 1, B_VSE = 2, B_BLKE = 3, B_TGEN = 5;

  typedef logic [N_SLOT-1:0][REG_W-1:0] regfile_t;
endpackage

// File: rtl/disp_tgen_regs.sv
module disp_tgen_regs
  import disp_tgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output regfile_t         regs_o
);
  logic     unlk_q;
  regfile_t regs_q;
  logic [N_SLOT-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unlk_q <= 1'b0;
    else if (we_i && addr_i == A_KEY) unlk_q <= (wdata_i[HALF_W-1:0] == UNLOCK_KEY);
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    assign hit[g] = (addr_i == SLOT_ADDR[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && unlk_q && hit[g]) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_KEY) rdata_o[0] = unlk_q;
    for (int i = 0; i < N_SLOT; i++)
      if (hit[i]) rdata_o = regs_q[i];
  end

  assign regs_o = regs_q;

  // R2
  locked_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlk_q && addr_i != A_KEY) |=> $stable(regs_q));
  // R1
  key_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_KEY && wdata_i[HALF_W-1:0] == UNLOCK_KEY) |=> unlk_q);
  // R1
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_KEY && wdata_i[HALF_W-1:0] != UNLOCK_KEY) |=> !unlk_q);
endmodule

// File: rtl/disp_tgen_cnt.sv
module disp_tgen_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] htot_i,
  input  logic [CNT_W-1:0] vtot_i,
  output logic [CNT_W-1:0] h_o,
  output logic [CNT_W-1:0] v_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= '0;
      v_o <= '0;
    end else if (!en_i) begin
      h_o <= '0;
      v_o <= '0;
    end else if (h_o >= htot_i) begin
      h_o <= '0;
      v_o <= (v_o >= vtot_i) ? '0 : v_o + 1'b1;
    end else begin
      h_o <= h_o + 1'b1;
    end
  end

  // R6
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (h_o == '0 && v_o == '0));
  // R5
  h_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && h_o >= htot_i) |=> h_o == '0);
  // R5
  v_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(h_o) < $past(htot_i)) |-> (v_o == $past(v_o)));
endmodule

// File: rtl/disp_tgen_win.sv
module disp_tgen_win #(
  parameter int unsigned CNT_W   = 16,
  parameter bit          LO_INCL = 1'b1
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             in_o
);
  logic lo_ok;
  if (LO_INCL) begin : g_incl
    assign lo_ok = (cnt_i >= lo_i);
  end else begin : g_excl
    assign lo_ok = (cnt_i > lo_i);
  end
  assign in_o = lo_ok && (cnt_i <= hi_i);
endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import disp_tgen_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] pix_o,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] vcnt_o,
  output logic             active_o,
  output logic             blank_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             fp_hsync_o,
  output logic             fp_vsync_o
);
  localparam int unsigned HI_LSB = HALF_W;

  regfile_t regs;
  logic [REG_W-1:0] cfg;
  logic tgen, blke;
  logic [N_WIN-1:0] win;
  logic [CNT_W-1:0] lo [N_WIN];
  logic [CNT_W-1:0] hi [N_WIN];
  logic unused_cfg;

  disp_tgen_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .regs_o(regs)
  );

  assign cfg  = regs[S_CFG];
  assign tgen = cfg[B_TGEN];
  assign blke = cfg[B_BLKE];
  assign unused_cfg = ^{cfg[REG_W-1:B_TGEN+1], cfg[4]};

  disp_tgen_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tgen),
    .htot_i(regs[S_HTOT][HI_LSB +: CNT_W]), .vtot_i(regs[S_VTOT][HI_LSB +: CNT_W]),
    .h_o(hcnt_o), .v_o(vcnt_o)
  );

  // even windows compare hcnt, odd windows vcnt
  always_comb begin
    lo[0] = '0;                       hi[0] = regs[S_HTOT][CNT_W-1:0];
    lo[1] = '0;                       hi[1] = regs[S_VTOT][CNT_W-1:0];
    lo[2] = regs[S_HBLK][CNT_W-1:0];  hi[2] = regs[S_HBLK][HI_LSB +: CNT_W];
    lo[3] = regs[S_VBLK][CNT_W-1:0];  hi[3] = regs[S_VBLK][HI_LSB +: CNT_W];
    lo[4] = regs[S_HSYN][CNT_W-1:0];  hi[4] = regs[S_HSYN][HI_LSB +: CNT_W];
    lo[5] = regs[S_VSYN][CNT_W-1:0];  hi[5] = regs[S_VSYN][HI_LSB +: CNT_W];
    lo[6] = regs[S_PHSYN][CNT_W-1:0]; hi[6] = regs[S_PHSYN][HI_LSB +: CNT_W];
    lo[7] = regs[S_PVSYN][CNT_W-1:0]; hi[7] = regs[S_PVSYN][HI_LSB +: CNT_W];
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    disp_tgen_win #(.CNT_W(CNT_W), .LO_INCL(g != 2 && g != 3)) u_win (
      .cnt_i((g % 2 == 0) ? hcnt_o : vcnt_o), .lo_i(lo[g]), .hi_i(hi[g]), .in_o(win[g])
    );
  end

  assign active_o   = tgen & blke & win[0] & win[1];
  assign blank_o    = ~tgen | ~blke | win[2] | win[3];
  assign hsync_o    = tgen & cfg[B_HSE] & win[4];
  assign vsync_o    = tgen & cfg[B_VSE] & win[5];
  assign fp_hsync_o = tgen & cfg[B_PDAT] & win[6];
  assign fp_vsync_o = tgen & cfg[B_PDAT] & win[7];
  assign pix_o      = active_o ? pix_i : '0;

  // R7
  active_not_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && regs[S_HBLK][CNT_W-1:0] == regs[S_HTOT][CNT_W-1:0]
              && regs[S_VBLK][CNT_W-1:0] == regs[S_VTOT][CNT_W-1:0]) |-> !blank_o);
endmodule

// File: tb/disp_tgen_tb.sv
module disp_tgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 6, HT = 10, HSS = 7, HSE = 9;
  localparam int VA = 4, VT = 7, VSS = 5, VSE = 6;

  logic clk = 0, rst_n = 0;
  logic we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0] pix_i = 0, pix_o;
  logic [15:0] hcnt, vcnt;
  logic active, blank, hs, vs, fhs, fvs;

  int checks = 0, failures = 0;
  bit done = 0;
  int mh = 0, mv = 0;
  logic [31:0] cfg_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_tgen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pix_i(pix_i), .pix_o(pix_o),
    .hcnt_o(hcnt), .vcnt_o(vcnt), .active_o(active), .blank_o(blank),
    .hsync_o(hs), .vsync_o(vs), .fp_hsync_o(fhs), .fp_vsync_o(fvs)
  );

  // raster model from R5/R6
  always @(posedge clk) begin
    if (!rst_n || !cfg_m[5]) begin mh = 0; mv = 0; end
    else if (mh >= HT-1) begin mh = 0; mv = (mv >= VT-1) ? 0 : mv + 1; end
    else mh = mh + 1;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
    if (a == 8'h08 && u_lk) cfg_m = d;
    if (a == 8'h00) u_lk = (d[15:0] == 16'h4758);
  endtask

  bit u_lk = 0;

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  function automatic logic [31:0] pk(input int hi, input int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) begin
      bit tg, be;
      logic e_act;
      tg = cfg_m[5]; be = cfg_m[3];
      pix_i = 8'(i * 37 + 5);
      #1;
      e_act = tg && be && mh < HA && mv < VA;
      chk("R5 hcnt", 32'(hcnt), 32'(mh));
      chk("R5 vcnt", 32'(vcnt), 32'(mv));
      chk("R7 active", 32'(active), 32'(e_act));
      chk("R7 pix", 32'(pix_o), e_act ? 32'(pix_i) : 32'd0);
      chk("R8 blank", 32'(blank), 32'(!tg || !be || mh >= HA || mv >= VA));
      chk("R9 hsync", 32'(hs), 32'(tg && cfg_m[1] && mh >= HSS-1 && mh <= HSE-1));
      chk("R9 vsync", 32'(vs), 32'(tg && cfg_m[2] && mv >= VSS-1 && mv <= VSE-1));
      chk("R10 fp_hsync", 32'(fhs), 32'(tg && cfg_m[0] && mh >= HSS-1 && mh <= HSE-1));
      chk("R10 fp_vsync", 32'(fvs), 32'(tg && cfg_m[0] && mv >= VSS-2 && mv <= VSE-2));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state locked, R6 idle outputs
    rd("R1 reset lock", 8'h00, 0);
    rd("R3 reset cfg", 8'h08, 0);
    chk("R6 reset blank", 32'(blank), 1);
    chk("R6 reset hsync", 32'(hs), 0);
    // R2 locked writes ignored
    wr(8'h30, 32'h1234_5678);
    rd("R2 locked htot", 8'h30, 0);
    wr(8'h08, 32'h2F);
    rd("R2 locked cfg", 8'h08, 0);
    chk("R2 locked no run", 32'(hcnt), 0);
    // R1 unlock, upper half ignored
    wr(8'h00, 32'hABCD_4758);
    rd("R1 unlocked", 8'h00, 1);
    wr(8'h30, pk(HT-1, HA-1));
    wr(8'h34, pk(HT-1, HA-1));
    wr(8'h38, pk(HSE-1, HSS-1));
    wr(8'h3C, pk(HSE-1, HSS-1));
    wr(8'h40, pk(VT-1, VA-1));
    wr(8'h44, pk(VT-1, VA-1));
    wr(8'h48, pk(VSE-1, VSS-1));
    wr(8'h4C, pk(VSE-2, VSS-2));
    rd("R4 htot", 8'h30, pk(HT-1, HA-1));
    rd("R4 hsync", 8'h38, pk(HSE-1, HSS-1));
    rd("R4 vtot", 8'h40, pk(VT-1, VA-1));
    rd("R4 fp_v", 8'h4C, pk(VSE-2, VSS-2));
    rd("R3 unmapped", 8'h50, 0);
    // full enable, two frames
    wr(8'h08, 32'h2F);
    sweep(2 * HT * VT);
    // relock, locked change ignored, readback kept
    wr(8'h00, 32'h0);
    rd("R1 relocked", 8'h00, 0);
    wr(8'h08, 32'h0);
    rd("R3 locked read", 8'h08, 32'h2F);
    sweep(HT * VT + 3);
    // gating variants, switched mid-frame
    wr(8'h00, 32'h4758);
    wr(8'h08, 32'h20);
    sweep(HT * VT);
    wr(8'h08, 32'h23);
    sweep(HT * VT);
    wr(8'h08, 32'h2D);
    sweep(HT * VT + 5);
    wr(8'h08, 32'h2E);
    sweep(HT * VT);
    // R6 disable mid-frame
    wr(8'h08, 32'h0F);
    sweep(HT * 2);
    wr(8'h08, 32'h2F);
    sweep(HT * VT);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=hang exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule